// File: doc/BRIEF.md
# Code-Group Lock Tracker with Selectable Loss Policy

This block watches a receive stream of 10-bit code groups after decoding and decides whether the link is locked to code-group boundaries. It takes one set of flags per code group, qualified by a valid strobe: comma present, invalid code, and running-disparity error. It reports a lock indication and the current state of its state machine. It does no deserialization, no alignment and no decoding itself.

Lock is gained by a fixed pattern of comma groups separated by data. The rule for losing lock is chosen at run time with a 2-bit select. Policy 00 is the default and uses a counted rule: errors are accumulated, and long runs of good groups pay them back. Policies 01, 10 and 11 drop lock at once after 1, 2 or 3 erroneous groups in a row. Changing the select restarts acquisition.

The state machine has four states, reported on `lock_state`:

- HUNT (0): searching for a comma.
- WANT_DATA (1): a comma was seen and a data group must follow.
- WANT_COMMA (2): data was seen and the next comma is awaited.
- LOCKED (3): locked.

The transitions are as follows:

- HUNT→WANT_DATA on a clean comma.
- WANT_DATA→WANT_COMMA on clean data.
- WANT_DATA→WANT_DATA on a repeated comma, which restarts the comma count at one.
- WANT_COMMA→WANT_COMMA on further data.
- WANT_COMMA→WANT_DATA on a comma that is not the last one needed.
- WANT_COMMA→LOCKED on the final comma.
- WANT_DATA or WANT_COMMA→HUNT on any error.
- LOCKED→HUNT when the loss policy fires.
- Any state→HUNT on reset or a select change.

Top module: `rx_lock_tracker`

## Requirements
- R1: Synchronous reset puts the machine in HUNT (`lock_state`=0) with `sync_ok`=0 and all error counters cleared; reset applied while locked drops lock.
- R2: A code group counts as erroneous when its invalid-code flag or its disparity-error flag is set, whether or not the comma flag is set. While `cg_valid` is low, all flags are ignored and the state does not change.
- R3: Lock is gained after 3 (COMMAS_TO_LOCK) clean commas, each pair separated by at least one clean data group. The state sequence is 1, 2, 1, 2, 3, and `sync_ok`=1 only in state 3. Two commas with no data group between them restart the count at one.
- R4: Any erroneous group accepted in state 1 or 2 returns the machine to HUNT.
- R5: With `hyst_sel`=00 while locked, each erroneous group raises an error count by one. Lock is lost on the group that would bring the count to 4 (ERR_LIMIT).
- R6: With `hyst_sel`=00, every 4 (GOOD_RUN) consecutive good groups lower a nonzero error count by one. A shorter run gives no credit, and an erroneous group restarts the run.
- R7: With `hyst_sel`=01, a single erroneous group while locked drops lock.
- R8: With `hyst_sel`=10, two erroneous groups in a row drop lock. Any good group clears the run of adjacent errors.
- R9: With `hyst_sel`=11, three erroneous groups in a row drop lock, and a good group clears the run.
- R10: A change of `hyst_sel` sends the machine to HUNT at the next clock edge, whether or not `cg_valid` is high, and clears every counter, so the error history does not carry into the next lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cg_valid | input | 1 | Flags below describe a new code group this cycle |
| cg_comma | input | 1 | Code group carries a comma |
| cg_bad_code | input | 1 | Code group is not a valid 10-bit code |
| cg_disp_err | input | 1 | Code group violates running disparity |
| hyst_sel | input | 2 | Loss policy: 00 counted, 01/10/11 drop after 1/2/3 adjacent errors |
| sync_ok | output | 1 | Lock achieved |
| lock_state | output | 2 | State: 0 HUNT, 1 WANT_DATA, 2 WANT_COMMA, 3 LOCKED |

## Verification
Every accepted code group acts at the rising edge that samples it, and both outputs are decoded straight from the state register, so the effect is visible one clock after the group is presented. A select change likewise shows HUNT one clock after the new value is applied. The bench drives each group at a falling edge and compares outputs at the following falling edge, so each check lands exactly one register stage after its stimulus. Counting-policy scenarios check the state after every group, so an early or late drop is caught at the group that caused it.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        ST_HUNT       = 2'd0,
        ST_WANT_DATA  = 2'd1,
        ST_WANT_COMMA = 2'd2,
        ST_LOCKED     = 2'd3
    } lock_state_e;

    typedef enum logic [1:0] {
        POL_COUNTED = 2'd0,
        POL_ADJ1    = 2'd1,
        POL_ADJ2    = 2'd2,
        POL_ADJ3    = 2'd3
    } loss_policy_e;

    typedef struct packed {
        logic valid;
        logic comma;
        logic err;
    } cg_event_t;

endpackage

// File: rtl/lock_event_decode.sv
module lock_event_decode
    import lock_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cg_valid,
    input  logic         cg_comma,
    input  logic         cg_bad_code,
    input  logic         cg_disp_err,
    input  logic [1:0]   hyst_sel,
    output cg_event_t    ev,
    output loss_policy_e policy,
    output logic         sel_chg
);

    logic [1:0] sel_q;

    always_ff @(posedge clk) begin
        sel_q <= hyst_sel;
    end

    always_comb begin
        ev.valid = cg_valid;
        ev.err   = cg_valid & (cg_bad_code | cg_disp_err);
        ev.comma = cg_valid & cg_comma;
        policy   = loss_policy_e'(hyst_sel);
        sel_chg  = !rst && (hyst_sel != sel_q);
    end

endmodule

// File: rtl/lock_loss_monitor.sv
module lock_loss_monitor
    import lock_pkg::*;
#(
    parameter int ERR_LIMIT = 4,
    parameter int GOOD_RUN  = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  cg_event_t    ev,
    input  loss_policy_e policy,
    output logic         drop
);

    localparam int EW = $clog2(ERR_LIMIT + 1);
    localparam int GW = $clog2(GOOD_RUN);
    localparam logic [EW-1:0] ERR_TOP  = EW'(ERR_LIMIT - 1);
    localparam logic [GW-1:0] GOOD_TOP = GW'(GOOD_RUN - 1);

    logic [EW-1:0] err_q, err_d;
    logic [GW-1:0] good_q, good_d;
    logic [1:0]    adj_q, adj_d;
    logic          hit;

    always_comb begin
        err_d  = err_q;
        good_d = good_q;
        adj_d  = adj_q;
        hit    = 1'b0;
        if (ev.valid) begin
            if (policy == POL_COUNTED) begin
                if (ev.err) begin
                    good_d = '0;
                    if (err_q == ERR_TOP) hit = 1'b1;
                    else                  err_d = err_q + 1'b1;
                end else if (err_q != '0) begin
                    if (good_q == GOOD_TOP) begin
                        good_d = '0;
                        err_d  = err_q - 1'b1;
                    end else begin
                        good_d = good_q + 1'b1;
                    end
                end
            end else begin
                if (ev.err) begin
                    if (({1'b0, adj_q} + 3'd1) >= {1'b0, policy}) hit = 1'b1;
                    else adj_d = adj_q + 1'b1;
                end else begin
                    adj_d = '0;
                end
            end
        end
        drop = hit & ~clear;
    end

    always_ff @(posedge clk) begin
        if (rst || clear || hit) begin
            err_q  <= '0;
            good_q <= '0;
            adj_q  <= '0;
        end else begin
            err_q  <= err_d;
            good_q <= good_d;
            adj_q  <= adj_d;
        end
    end

    // R8 / R9: a good group while locked wipes the adjacent-error run
    p_good_clears_run_r8: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && !ev.err && policy != POL_COUNTED) |=> (adj_q == 2'd0));

    // R5: the count never sits at or above the limit
    p_err_below_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (err_q < EW'(ERR_LIMIT)));

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
#(
    parameter int COMMAS_TO_LOCK = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  cg_event_t   ev,
    input  logic        sel_chg,
    input  logic        drop,
    output lock_state_e state_q,
    output logic        sync_ok,
    output logic        mon_clear
);

    localparam int CW = $clog2(COMMAS_TO_LOCK + 1);
    localparam logic [CW-1:0] LAST_COMMA = CW'(COMMAS_TO_LOCK - 1);

    lock_state_e   state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (sel_chg) begin
            state_d = ST_HUNT;
            cnt_d   = '0;
        end else if (ev.valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (ev.comma && !ev.err) begin
                        state_d = ST_WANT_DATA;
                        cnt_d   = CW'(1);
                    end
                end
                ST_WANT_DATA: begin
                    if (ev.err) begin
                        state_d = ST_HUNT;
                        cnt_d   = '0;
                    end else if (ev.comma) begin
                        cnt_d = CW'(1);
                    end else begin
                        state_d = ST_WANT_COMMA;
                    end
                end
                ST_WANT_COMMA: begin
                    if (ev.err) begin
                        state_d = ST_HUNT;
                        cnt_d   = '0;
                    end else if (ev.comma) begin
                        if (cnt_q == LAST_COMMA) begin
                            state_d = ST_LOCKED;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_WANT_DATA;
                            cnt_d   = cnt_q + 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (drop) state_d = ST_HUNT;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        sync_ok   = (state_q == ST_LOCKED);
        mon_clear = (state_q != ST_LOCKED) || sel_chg;
    end

    // R3: lock is only entered on a clean comma
    p_lock_on_comma_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCKED && $past(state_q) != ST_LOCKED)
            |-> $past(ev.comma && !ev.err));

    // R4: errors during acquisition go back to hunting
    p_acq_error_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && ev.err && !sel_chg &&
         (state_q == ST_WANT_DATA || state_q == ST_WANT_COMMA))
            |=> (state_q == ST_HUNT));

    // R2: no strobe, no movement
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ev.valid && !sel_chg) |=> $stable(state_q));

    // R10: select change restarts acquisition
    p_sel_restart_r10: assert property (@(posedge clk) disable iff (rst)
        sel_chg |=> (state_q == ST_HUNT));

endmodule

// File: rtl/rx_lock_tracker.sv
module rx_lock_tracker
    import lock_pkg::*;
#(
    parameter int COMMAS_TO_LOCK = 3,
    parameter int ERR_LIMIT      = 4,
    parameter int GOOD_RUN       = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cg_valid,
    input  logic       cg_comma,
    input  logic       cg_bad_code,
    input  logic       cg_disp_err,
    input  logic [1:0] hyst_sel,
    output logic       sync_ok,
    output logic [1:0] lock_state
);

    cg_event_t    ev;
    loss_policy_e policy;
    logic         sel_chg;
    logic         drop;
    logic         mon_clear;
    lock_state_e  state_q;

    lock_event_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .cg_valid    (cg_valid),
        .cg_comma    (cg_comma),
        .cg_bad_code (cg_bad_code),
        .cg_disp_err (cg_disp_err),
        .hyst_sel    (hyst_sel),
        .ev          (ev),
        .policy      (policy),
        .sel_chg     (sel_chg)
    );

    lock_loss_monitor #(
        .ERR_LIMIT (ERR_LIMIT),
        .GOOD_RUN  (GOOD_RUN)
    ) u_monitor (
        .clk    (clk),
        .rst    (rst),
        .clear  (mon_clear),
        .ev     (ev),
        .policy (policy),
        .drop   (drop)
    );

    lock_fsm #(
        .COMMAS_TO_LOCK (COMMAS_TO_LOCK)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sel_chg   (sel_chg),
        .drop      (drop),
        .state_q   (state_q),
        .sync_ok   (sync_ok),
        .mon_clear (mon_clear)
    );

    assign lock_state = state_q;

    // R7: one error under the single-error policy ends lock
    p_single_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_ok && cg_valid && cg_bad_code && hyst_sel == 2'b01 && !sel_chg)
            |=> !sync_ok);

    // R1: lock is never reported the cycle after reset
    p_reset_clears_r1: assert property (@(posedge clk)
        $past(rst) |-> (!sync_ok && lock_state == 2'd0));

endmodule

// File: tb/rx_lock_tracker_tb_top.sv
module rx_lock_tracker_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cg_valid = 1'b0;
    logic       cg_comma = 1'b0;
    logic       cg_bad_code = 1'b0;
    logic       cg_disp_err = 1'b0;
    logic [1:0] hyst_sel = 2'b00;
    logic       sync_ok;
    logic [1:0] lock_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_lock_tracker dut_i (
        .clk         (clk),
        .rst         (rst),
        .cg_valid    (cg_valid),
        .cg_comma    (cg_comma),
        .cg_bad_code (cg_bad_code),
        .cg_disp_err (cg_disp_err),
        .hyst_sel    (hyst_sel),
        .sync_ok     (sync_ok),
        .lock_state  (lock_state)
    );

    task automatic expect_st(input logic [1:0] st, input string req);
        logic exp_sync;
        exp_sync = (st == 2'd3);
        n_checks++;
        if (lock_state !== st || sync_ok !== exp_sync) begin
            n_fail++;
            $display("FAIL %s: state=%0d sync=%0b expected state=%0d sync=%0b",
                     req, lock_state, sync_ok, st, exp_sync);
        end
    endtask

    // one code group, outputs valid on return (next falling edge)
    task automatic cg(input logic c, input logic bad, input logic disp);
        cg_valid = 1'b1; cg_comma = c; cg_bad_code = bad; cg_disp_err = disp;
        @(negedge clk);
        cg_valid = 1'b0; cg_comma = 1'b0; cg_bad_code = 1'b0; cg_disp_err = 1'b0;
    endtask

    task automatic good(); cg(1'b0, 1'b0, 1'b0); endtask
    task automatic bad();  cg(1'b0, 1'b1, 1'b0); endtask
    task automatic derr(); cg(1'b0, 1'b0, 1'b1); endtask
    task automatic comma(); cg(1'b1, 1'b0, 1'b0); endtask

    task automatic acquire(input string req);
        comma(); good(); comma(); good(); comma();
        expect_st(2'd3, req);
    endtask

    task automatic set_mode(input logic [1:0] m, input string req);
        hyst_sel = m;
        @(negedge clk);
        expect_st(2'd0, req);
    endtask

    task automatic t_reset();
        expect_st(2'd0, "R1 reset state");
    endtask

    task automatic t_acquire_seq();
        comma(); expect_st(2'd1, "R3 first comma");
        good();  expect_st(2'd2, "R3 data after comma");
        good();  expect_st(2'd2, "R3 extra data");
        comma(); expect_st(2'd1, "R3 second comma");
        good();  expect_st(2'd2, "R3 data");
        comma(); expect_st(2'd3, "R3 third comma locks");
    endtask

    task automatic t_back_to_back();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        comma(); comma(); comma();
        expect_st(2'd1, "R3 adjacent commas do not lock");
        good(); comma(); good();
        expect_st(2'd2, "R3 count restarted at one");
        comma();
        expect_st(2'd3, "R3 lock after restart");
    endtask

    task automatic t_acq_errors();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        comma(); bad();
        expect_st(2'd0, "R4 error in state 1");
        comma(); good(); derr();
        expect_st(2'd0, "R4 disparity error in state 2");
        comma(); good(); cg(1'b1, 1'b1, 1'b0);
        expect_st(2'd0, "R2 comma with bad code is an error");
    endtask

    task automatic t_valid_low();
        acquire("R3 lock before idle test");
        cg_bad_code = 1'b1; cg_disp_err = 1'b1;
        repeat (6) @(negedge clk);
        cg_bad_code = 1'b0; cg_disp_err = 1'b0;
        expect_st(2'd3, "R2 flags ignored without strobe");
    endtask

    task automatic t_counted();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        acquire("R5 lock");
        bad(); bad(); bad();
        expect_st(2'd3, "R5 three errors keep lock");
        bad();
        expect_st(2'd0, "R5 fourth error drops lock");
        acquire("R6 relock");
        bad(); derr(); bad();
        good(); good(); good(); good();
        bad();
        expect_st(2'd3, "R6 four good repay one error");
        bad();
        expect_st(2'd0, "R6 count back at limit");
        acquire("R6 relock 2");
        bad(); bad(); bad();
        good(); good(); good();
        bad();
        expect_st(2'd0, "R6 three good give no credit");
        acquire("R6 relock 3");
        bad(); bad(); bad();
        good(); good(); good(); bad(); // run restarts, no credit
        expect_st(2'd0, "R6 error restarts good run");
    endtask

    task automatic t_adj1();
        set_mode(2'b01, "R10 select change to 01");
        acquire("R7 lock");
        good(); good();
        derr();
        expect_st(2'd0, "R7 single error drops");
    endtask

    task automatic t_adj2();
        set_mode(2'b10, "R10 select change to 10");
        acquire("R8 lock");
        bad(); good(); derr(); good(); bad();
        expect_st(2'd3, "R8 separated errors keep lock");
        bad();
        expect_st(2'd0, "R8 two adjacent errors drop");
    endtask

    task automatic t_adj3();
        set_mode(2'b11, "R10 select change to 11");
        acquire("R9 lock");
        bad(); derr(); good(); bad(); bad();
        expect_st(2'd3, "R9 two adjacent keep lock");
        bad();
        expect_st(2'd0, "R9 three adjacent drop");
    endtask

    task automatic t_sel_change();
        set_mode(2'b10, "R10 back to 10");
        acquire("R10 lock");
        bad();
        hyst_sel = 2'b11;
        @(negedge clk);
        expect_st(2'd0, "R10 change while locked");
        acquire("R10 relock");
        bad(); bad();
        expect_st(2'd3, "R10 history cleared");
        good();
        comma();
        hyst_sel = 2'b00;
        @(negedge clk);
        expect_st(2'd0, "R10 change with strobe low");
    endtask

    task automatic t_mid_reset();
        acquire("R1 lock before reset");
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        expect_st(2'd0, "R1 reset drops lock");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_acquire_seq();
        t_valid_low();
        t_back_to_back();
        t_acq_errors();
        t_counted();
        t_adj1();
        t_adj2();
        t_adj3();
        t_sel_change();
        t_mid_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule